// File: doc/BRIEF.md
# Non-Volatile Store Sequencer with Ready/Busy

This block decides when a channel value that has just come in over a serial link gets committed into non-volatile storage, and it runs that commit. It does not parse frames. An upstream parser presents one pulse per completed frame, together with the channel number and the data byte, on the same clock as the serial edge that carried the last data bit. Each frame immediately becomes a temporary working setting for its channel. The frame word is also held as pending for a short window. If the program input is high on the first serial edge after the frame edge, the word is committed. If it is not, the word expires one serial edge later.

A commit is a timed erase/write cycle whose length is counted in serial-clock rising edges. System clocks that carry no serial edge do not advance it. An active-low busy line (`ready_o`) reports the cycle. The busy state is gated by a supply-good input. When the supply is low as a request is accepted, the cycle never starts. When the supply falls during a cycle, the cycle aborts. In both cases the stored value stays as it was and the line reads ready. Deselecting the link copies every stored value back into the working registers. The first clock after reset does the same thing, with no serial edge needed, which acts as the power-on load.

Top module: `nv_store_seq`

## Requirements
- R1: While reset is asserted, every working register reads 0 and `ready_o` is 1. On the first clock after reset is released, the working registers take the stored power-on contents, with channel i set to (i+1)*0x21 modulo 256 (0x21, 0x42, 0x63, 0x84). No `sclk_rise` is needed for this.
- R2: A clock that has `sel`, `sclk_rise` and `frame_done` high while the block is not busy writes `frame_data` into the working register of `frame_chan`. The change appears in `level_o` on the next clock, and the other channels stay unchanged.
- R3: A clock with `sel` low loads every working register from the stored values, visible on the next clock. It also discards any pending word.
- R4: If `prog` is high on the first `sclk_rise` after the frame edge and `supply_ok` is high, the request is accepted and `ready_o` goes to 0 on the next clock.
- R5: A pending word expires on the second `sclk_rise` after its frame edge. Raising `prog` at that edge or later starts nothing, and the stored value is unchanged.
- R6: Once accepted, the cycle lasts exactly BUSY_EDGES further `sclk_rise` pulses. `ready_o` returns to 1 on the clock after the last of them, and clocks without `sclk_rise` do not advance it.
- R7: When a cycle completes, the stored value of the channel latched at acceptance takes the latched data. A later deselect therefore shows that new value.
- R8: If `supply_ok` is low on the clock a request would be accepted, `ready_o` stays 1 and the stored value is unchanged.
- R9: If `supply_ok` drops while busy, `ready_o` returns to 1 on the next clock and the stored value is not updated.
- R10: While busy, `link_en` is 0 and frames are ignored. They change neither the working registers nor the pending word.
- R11: Channel c occupies bits `level_o[c*8 +: 8]`. `frame_chan` takes the values 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk_rise | input | 1 | One-clock strobe for each serial-clock rising edge |
| sel | input | 1 | Link select, active high; low restores stored values |
| frame_done | input | 1 | Frame complete, valid together with `sclk_rise` |
| frame_chan | input | 2 | Channel of the completed frame |
| frame_data | input | 8 | Data byte of the completed frame |
| prog | input | 1 | Program request level |
| supply_ok | input | 1 | Supply high enough to write storage |
| ready_o | output | 1 | 1 = ready, 0 = erase/write cycle running |
| link_en | output | 1 | Serial input accepted and serial output may drive |
| level_o | output | 32 | Working registers of all channels, packed |

## Verification
The embedded properties assume that `frame_done` only arrives together with `sclk_rise`. They also assume that inputs change once per system clock, so a frame edge and the edge after it are never the same clock. The stimulus drives every input just after a rising clock edge. It issues each serial edge as a one-clock strobe followed by a quiet clock. It changes `prog` and `supply_ok` only on quiet clocks. This also exercises the rule that quiet clocks do not advance the busy count.

// File: rtl/nv_store_pkg.sv
package nv_store_pkg;
  localparam int NV_CH  = 4;
  localparam int NV_W   = 8;
  localparam int NV_CHW = $clog2(NV_CH);

  typedef logic [NV_CHW-1:0] nv_chan_t;

  typedef struct packed {
    nv_chan_t        ch;
    logic [NV_W-1:0] dat;
  } nv_word_t;
endpackage

// File: rtl/nv_pend_window.sv
module nv_pend_window
  import nv_store_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sclk_rise,
  input  logic     sel,
  input  logic     busy,
  input  logic     frame_done,
  input  logic     prog,
  input  nv_word_t frame_word,
  output logic     arm,
  output nv_word_t arm_word
);
  logic     vld_q, vld_d;
  logic     age_q, age_d;
  nv_word_t w_q;
  logic     load;

  assign load     = sel & sclk_rise & frame_done & ~busy;
  assign arm      = sel & sclk_rise & vld_q & ~age_q & prog & ~frame_done;
  assign arm_word = w_q;

  always_comb begin
    vld_d = vld_q;
    age_d = age_q;
    if (!sel) begin
      vld_d = 1'b0;
    end else if (sclk_rise) begin
      if (frame_done && !busy) begin
        vld_d = 1'b1;
        age_d = 1'b0;
      end else if (vld_q) begin
        if (!age_q && !prog) age_d = 1'b1;
        else                 vld_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      age_q <= 1'b0;
      w_q   <= '0;
    end else begin
      vld_q <= vld_d;
      age_q <= age_d;
      if (load) w_q <= frame_word;
    end
  end

  AST_PEND_EXPIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && age_q && sclk_rise && !frame_done) |=> !vld_q); // R5
endmodule

// File: rtl/nv_busy_timer.sv
module nv_busy_timer
  import nv_store_pkg::*;
#(
  parameter int BUSY_EDGES = 4000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sclk_rise,
  input  logic     supply_ok,
  input  logic     start,
  input  nv_word_t start_word,
  output logic     busy,
  output logic     commit,
  output nv_word_t commit_word
);
  localparam int            CW   = $clog2(BUSY_EDGES + 1);
  localparam logic [CW-1:0] LAST = CW'(BUSY_EDGES - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  nv_word_t      word_q;
  logic          last_edge;

  assign last_edge   = busy_q & sclk_rise & (cnt_q == LAST);
  assign commit      = last_edge & supply_ok;
  assign busy        = busy_q;
  assign commit_word = word_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      if (!supply_ok)       busy_d = 1'b0;
      else if (last_edge)   busy_d = 1'b0;
      else if (sclk_rise)   cnt_d  = cnt_q + 1'b1;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      word_q <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      if (start && !busy_q) word_q <= start_word;
    end
  end

  AST_HOLD_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !sclk_rise && supply_ok) |=> busy_q); // R6
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q); // R10
endmodule

// File: rtl/nv_reg_bank.sv
module nv_reg_bank
  import nv_store_pkg::*;
#(
  parameter logic [NV_W-1:0] INIT_STEP = 8'h21
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel,
  input  logic                   wr_en,
  input  nv_word_t               wr_word,
  input  logic                   commit,
  input  nv_word_t               commit_word,
  output logic [NV_CH*NV_W-1:0]  level_o
);
  logic            boot_q;
  logic [NV_W-1:0] st_q [NV_CH];
  logic [NV_W-1:0] wk_q [NV_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_q <= 1'b1;
    else        boot_q <= 1'b0;
  end

  for (genvar i = 0; i < NV_CH; i++) begin : g_ch
    logic st_en, wk_wr;
    assign st_en = commit & (commit_word.ch == NV_CHW'(i));
    assign wk_wr = wr_en & (wr_word.ch == NV_CHW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q[i] <= NV_W'((i + 1) * INIT_STEP);
      else if (st_en) st_q[i] <= commit_word.dat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                wk_q[i] <= '0;
      else if (boot_q || !sel)   wk_q[i] <= st_q[i];
      else if (wk_wr)            wk_q[i] <= wr_word.dat;
    end

    assign level_o[i*NV_W +: NV_W] = wk_q[i];

    AST_BOOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      boot_q |=> (wk_q[i] == $past(st_q[i]))); // R1
    AST_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel && !boot_q) |=> (wk_q[i] == $past(st_q[i]))); // R3
  end
endmodule

// File: rtl/nv_store_seq.sv
module nv_store_seq
  import nv_store_pkg::*;
#(
  parameter int              BUSY_EDGES = 4000,
  parameter logic [NV_W-1:0] INIT_STEP  = 8'h21
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_rise,
  input  logic                  sel,
  input  logic                  frame_done,
  input  logic [NV_CHW-1:0]     frame_chan,
  input  logic [NV_W-1:0]       frame_data,
  input  logic                  prog,
  input  logic                  supply_ok,
  output logic                  ready_o,
  output logic                  link_en,
  output logic [NV_CH*NV_W-1:0] level_o
);
  nv_word_t frame_word, arm_word, commit_word;
  logic     busy, arm, start, commit, wr_en;

  assign frame_word = '{ch: frame_chan, dat: frame_data};
  assign wr_en      = sel & sclk_rise & frame_done & ~busy;
  assign start      = arm & supply_ok;
  assign ready_o    = ~busy;
  assign link_en    = sel & ~busy;

  nv_pend_window u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_rise  (sclk_rise),
    .sel        (sel),
    .busy       (busy),
    .frame_done (frame_done),
    .prog       (prog),
    .frame_word (frame_word),
    .arm        (arm),
    .arm_word   (arm_word)
  );

  nv_busy_timer #(.BUSY_EDGES(BUSY_EDGES)) u_tmr (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_rise   (sclk_rise),
    .supply_ok   (supply_ok),
    .start       (start),
    .start_word  (arm_word),
    .busy        (busy),
    .commit      (commit),
    .commit_word (commit_word)
  );

  nv_reg_bank #(.INIT_STEP(INIT_STEP)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (sel),
    .wr_en       (wr_en),
    .wr_word     (frame_word),
    .commit      (commit),
    .commit_word (commit_word),
    .level_o     (level_o)
  );

  AST_FALL_NEEDS_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_o) |-> $past(prog)); // R4
  AST_LINK_OFF_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> !link_en); // R10
  AST_LOWSUPPLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> ready_o); // R8
endmodule

// File: tb/tb_nv_store_seq.sv
module tb_nv_store_seq;
  localparam int N = 10;

  logic        clk = 1'b0;
  logic        rst_n, sclk_rise, sel, frame_done, prog, supply_ok;
  logic [1:0]  frame_chan;
  logic [7:0]  frame_data;
  logic        ready_o, link_en;
  logic [31:0] level_o;

  int    vec = 0, bad = 0;
  string phase = "R1";

  always #5 clk = ~clk;

  nv_store_seq #(.BUSY_EDGES(N)) dut (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sel(sel),
    .frame_done(frame_done), .frame_chan(frame_chan), .frame_data(frame_data),
    .prog(prog), .supply_ok(supply_ok), .ready_o(ready_o), .link_en(link_en),
    .level_o(level_o)
  );

  // behavioural reference
  logic [7:0] st [4];
  logic [7:0] wk [4];
  bit boot, pend, age, bsy;
  int pch, pdat, left, bch, bdat;

  function automatic logic [31:0] exp_level();
    return {wk[3], wk[2], wk[1], wk[0]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin st[i] = 8'((i + 1) * 33); wk[i] = 8'h00; end
      boot = 1; pend = 0; age = 0; bsy = 0; left = 0;
    end else begin
      logic [7:0] old_st [4];
      bit arm, wfr, bsy_pre;
      for (int i = 0; i < 4; i++) old_st[i] = st[i];
      bsy_pre = bsy;
      arm = sel && sclk_rise && pend && !age && prog && !frame_done;
      wfr = sel && sclk_rise && frame_done && !bsy_pre;
      if (!sel) pend = 0;
      else if (sclk_rise) begin
        if (wfr) begin pend = 1; age = 0; pch = frame_chan; pdat = frame_data; end
        else if (pend) begin
          if (!age && !prog) age = 1; else pend = 0;
        end
      end
      if (bsy_pre) begin
        if (!supply_ok) bsy = 0;
        else if (sclk_rise) begin
          left--;
          if (left == 0) begin bsy = 0; st[bch] = 8'(bdat); end
        end
      end else if (arm && supply_ok && !wfr) begin
        bsy = 1; left = N; bch = pch; bdat = pdat;
      end
      if (boot || !sel) for (int i = 0; i < 4; i++) wk[i] = old_st[i];
      else if (wfr) wk[frame_chan] = frame_data;
      boot = 0;
    end
  end

  always @(negedge clk) begin
    vec++;
    if (ready_o !== !bsy || link_en !== (sel && !bsy) || level_o !== exp_level()) begin
      bad++;
      $display("FAIL %s: ready=%b link=%b level=%h expected ready=%b link=%b level=%h",
               phase, ready_o, link_en, level_o, !bsy, sel && !bsy, exp_level());
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic sedge(input logic fd, input logic [1:0] ch, input logic [7:0] d);
    sclk_rise = 1; frame_done = fd; frame_chan = ch; frame_data = d;
    step();
    sclk_rise = 0; frame_done = 0;
    step();
  endtask

  task automatic deselect();
    sel = 0; step(); sel = 1;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    rst_n = 0; sclk_rise = 0; sel = 1; frame_done = 0; frame_chan = 0;
    frame_data = 0; prog = 0; supply_ok = 1;
    #23;
    chk("R1", {31'd0, ready_o}, 32'd1);
    chk("R1", level_o, 32'h0);
    rst_n = 1; step();
    chk("R1", level_o, 32'h84634221);

    phase = "R2";
    sedge(1, 2'd2, 8'hA5); sedge(0, 0, 0); sedge(0, 0, 0);
    chk("R2", level_o, 32'h84A54221);   // R11 channel 2 field
    phase = "R3";
    deselect();
    chk("R3", level_o, 32'h84634221);

    phase = "R5";
    sedge(1, 2'd1, 8'h5A); sedge(0, 0, 0);
    prog = 1; sedge(0, 0, 0); sedge(0, 0, 0); prog = 0; step();
    chk("R5", {31'd0, ready_o}, 32'd1);
    deselect();
    chk("R5", level_o, 32'h84634221);

    phase = "R4";
    prog = 1; sedge(1, 2'd1, 8'h77); sedge(0, 0, 0);
    chk("R4", {31'd0, ready_o}, 32'd0);
    prog = 0;
    phase = "R10";
    sedge(1, 2'd0, 8'h99);
    chk("R10", level_o, 32'h84637721);
    chk("R10", {31'd0, link_en}, 32'd0);
    phase = "R6";
    for (int k = 0; k < N - 2; k++) begin sedge(0, 0, 0); step(); end
    chk("R6", {31'd0, ready_o}, 32'd0);
    sedge(0, 0, 0);
    chk("R6", {31'd0, ready_o}, 32'd1);
    phase = "R7";
    deselect();
    chk("R7", level_o, 32'h84637721);

    phase = "R8";
    supply_ok = 0; step();
    prog = 1; sedge(1, 2'd3, 8'h0F); sedge(0, 0, 0); prog = 0;
    chk("R8", {31'd0, ready_o}, 32'd1);
    supply_ok = 1; step();
    for (int k = 0; k < N + 2; k++) sedge(0, 0, 0);
    deselect();
    chk("R8", level_o, 32'h84637721);

    phase = "R9";
    prog = 1; sedge(1, 2'd0, 8'h3C); sedge(0, 0, 0); prog = 0;
    chk("R9", {31'd0, ready_o}, 32'd0);
    sedge(0, 0, 0); sedge(0, 0, 0);
    supply_ok = 0; step();
    chk("R9", {31'd0, ready_o}, 32'd1);
    supply_ok = 1;
    for (int k = 0; k < N + 2; k++) sedge(0, 0, 0);
    deselect();
    chk("R9", level_o, 32'h84637721);

    phase = "R11";
    sedge(1, 2'd3, 8'hE7); step();
    chk("R11", level_o, 32'hE7637721);
    step(); step();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule